// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port access of one, two or four bytes may go ahead, using a permission bitmap that lives in memory next to the current task descriptor. When `start_i` is pulsed, the block samples the descriptor (present flag, 4-bit type, base address and limit), the port number and the access size. It first validates the descriptor and the size without touching memory. It then reads two 16-bit words over a request/valid read port. The first word is a pointer to the start of the bitmap. The second word holds the permission bits for the addressed port and the ports next to it.

The block always fetches two bytes of bitmap. An access that crosses from one bitmap byte into the next is therefore judged on every bit it covers. A set bit means the port is denied. The result comes back as a single-cycle `done_o` pulse with exactly one of `allow_o` or `fault_o` high. A fault stands for a general-protection fault whose error code is zero. Delivering the exception and making the port transfer are the job of the surrounding logic.

Top module: `iopb_checker`

## Requirements
- R1: After reset `done_o`, `allow_o`, `fault_o` and `mem_req_o` are all low.
- R2: If the descriptor is not present, its type is not 9, or its limit is below 103, the block raises `fault_o` with `done_o` in the cycle after start and issues no memory request.
- R3: A size other than 1, 2 or 4 gives a fault in the cycle after start, with no memory request.
- R4: For a valid descriptor and size, the first memory request is raised in the cycle after start, at address descriptor base + 0x66. The word returned is the 16-bit bitmap pointer.
- R5: The second request addresses descriptor base + (pointer + (port >> 3)). The bracketed sum is formed in 17 bits, so a pointer near 0xFFFF carries into bit 16 and does not wrap.
- R6: If that 17-bit byte offset plus one is greater than the descriptor limit, the block faults right after the first read and makes no second request.
- R7: The second word is little-endian: bit k is permission bit k of byte offset, and bit 8+k is bit k of the next byte. The word is shifted right by port[2:0], and its low `size` bits are tested. The access is allowed only if all of those bits are zero, and a fault is given otherwise. This holds when the tested bits span two bytes.
- R8: `done_o` is high for exactly one cycle per check, in the cycle after the deciding event. While it is high, exactly one of `allow_o` and `fault_o` is set. Both are low when `done_o` is low.
- R9: A start that arrives while a check is in progress is ignored. It has no effect on the result, on the number of reads or on their addresses.
- R10: While `mem_req_o` is high and `mem_valid_i` is low, the request stays high and `mem_addr_o` stays stable. A read completes in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check; sampled only when idle |
| port_i | input | 16 | Port number of the access |
| size_i | input | 3 | Access width in bytes (1, 2 or 4) |
| desc_present_i | input | 1 | Task descriptor present flag |
| desc_type_i | input | 4 | Task descriptor type field |
| desc_base_i | input | 32 | Task descriptor base address |
| desc_limit_i | input | 32 | Task descriptor limit (last valid byte offset) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Byte address of the 16-bit word requested |
| mem_valid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 16 | Read data, lower address in bits 7:0 |
| done_o | output | 1 | One-cycle result strobe |
| allow_o | output | 1 | Access permitted (with done_o) |
| fault_o | output | 1 | General-protection fault, error code zero (with done_o) |

## Verification
The assertions take two things for granted. The descriptor, port and size inputs are only meaningful in the cycle where `start_i` meets an idle block, which shows at the ports as `mem_req_o` low. Memory answers only while a request is pending. The bench drives `mem_valid_i` from the request itself after a latency that varies from check to check, so data never arrives unasked. It changes the descriptor inputs only together with a start, except in the busy-start test, where a second start is sent on purpose to show that it is dropped.

// File: rtl/iopb_pkg.sv
`timescale 1ns/1ps
package iopb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_MAP  = 2'd2
    } iopb_state_e;

endpackage

// File: rtl/iopb_desc_check.sv
`timescale 1ns/1ps
// Validates the task descriptor and the access width before any read.
module iopb_desc_check #(
    parameter int LW        = 32,
    parameter int TYPE_W    = 4,
    parameter int SZW       = 3,
    parameter int TYPE_OK   = 9,
    parameter int MIN_LIMIT = 103
) (
    input  logic              present_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [LW-1:0]     limit_i,
    input  logic [SZW-1:0]    size_i,
    output logic              desc_ok_o,
    output logic              size_ok_o
);
    localparam logic [TYPE_W-1:0] TYPE_VAL = TYPE_W'(TYPE_OK);
    localparam logic [LW-1:0]     LIM_MIN  = LW'(MIN_LIMIT);

    always_comb begin
        desc_ok_o = present_i && (type_i == TYPE_VAL) && (limit_i >= LIM_MIN);
        size_ok_o = (size_i == SZW'(1)) || (size_i == SZW'(2)) || (size_i == SZW'(4));
    end
endmodule

// File: rtl/iopb_offset_calc.sv
`timescale 1ns/1ps
// Byte offset of the bitmap word and the two-byte limit test.
module iopb_offset_calc #(
    parameter int DW = 16,
    parameter int HW = 13,
    parameter int LW = 32,
    localparam int OFS_W = DW + 1
) (
    input  logic [DW-1:0]    ptr_i,
    input  logic [HW-1:0]    port_hi_i,
    input  logic [LW-1:0]    limit_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             over_o
);
    localparam int CW = ((LW > OFS_W) ? LW : OFS_W) + 1;

    logic [CW-1:0] ofs_ext;
    logic [CW-1:0] lim_ext;

    always_comb begin
        ofs_o   = OFS_W'(ptr_i) + OFS_W'(port_hi_i);
        ofs_ext = CW'(ofs_o);
        lim_ext = CW'(limit_i);
        over_o  = (ofs_ext + CW'(1)) > lim_ext;
    end
endmodule

// File: rtl/iopb_mask_eval.sv
`timescale 1ns/1ps
// Tests the permission bits covered by the access inside the fetched word.
module iopb_mask_eval #(
    parameter int DW  = 16,
    parameter int SZW = 3,
    parameter int NL  = 4,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0]  word_i,
    input  logic [2:0]     sel_i,
    input  logic [SZW-1:0] size_i,
    output logic           clear_o
);
    logic [NL-1:0] hit;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [IW-1:0] idx;
        always_comb begin
            idx    = IW'(sel_i) + IW'(i);
            hit[i] = word_i[idx] && (size_i > SZW'(i));
        end
    end

    always_comb clear_o = ~|hit;
endmodule

// File: rtl/iopb_checker.sv
`timescale 1ns/1ps
module iopb_checker
    import iopb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LW        = 32,
    parameter int PW        = 16,
    parameter int DW        = 16,
    parameter int TYPE_W    = 4,
    parameter int SZW       = 3,
    parameter int PTR_OFS   = 'h66,
    parameter int TYPE_OK   = 9,
    parameter int MIN_LIMIT = 103,
    parameter int MAX_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PW-1:0]     port_i,
    input  logic [SZW-1:0]    size_i,
    input  logic              desc_present_i,
    input  logic [TYPE_W-1:0] desc_type_i,
    input  logic [AW-1:0]     desc_base_i,
    input  logic [LW-1:0]     desc_limit_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              done_o,
    output logic              allow_o,
    output logic              fault_o
);
    localparam int HW    = PW - 3;
    localparam int OFS_W = DW + 1;

    typedef struct packed {
        iopb_state_e     state;
        logic [PW-1:0]   port;
        logic [SZW-1:0]  size;
        logic [AW-1:0]   base;
        logic [LW-1:0]   limit;
        logic [AW-1:0]   addr;
        logic            done;
        logic            allow;
    } regs_t;

    regs_t r_d, r_q;

    logic             desc_ok, size_ok;
    logic [OFS_W-1:0] map_ofs;
    logic             map_over;
    logic             map_clear;

    iopb_desc_check #(
        .LW(LW), .TYPE_W(TYPE_W), .SZW(SZW),
        .TYPE_OK(TYPE_OK), .MIN_LIMIT(MIN_LIMIT)
    ) u_desc (
        .present_i (desc_present_i),
        .type_i    (desc_type_i),
        .limit_i   (desc_limit_i),
        .size_i    (size_i),
        .desc_ok_o (desc_ok),
        .size_ok_o (size_ok)
    );

    iopb_offset_calc #(.DW(DW), .HW(HW), .LW(LW)) u_ofs (
        .ptr_i     (mem_rdata_i),
        .port_hi_i (r_q.port[PW-1:3]),
        .limit_i   (r_q.limit),
        .ofs_o     (map_ofs),
        .over_o    (map_over)
    );

    iopb_mask_eval #(.DW(DW), .SZW(SZW), .NL(MAX_BYTES)) u_mask (
        .word_i  (mem_rdata_i),
        .sel_i   (r_q.port[2:0]),
        .size_i  (r_q.size),
        .clear_o (map_clear)
    );

    // next-state logic
    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.allow = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.port  = port_i;
                    r_d.size  = size_i;
                    r_d.base  = desc_base_i;
                    r_d.limit = desc_limit_i;
                    if (!desc_ok || !size_ok) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.addr  = desc_base_i + AW'(PTR_OFS);
                        r_d.state = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                if (mem_valid_i) begin
                    if (map_over) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.addr  = r_q.base + AW'(map_ofs);
                        r_d.state = ST_MAP;
                    end
                end
            end
            ST_MAP: begin
                if (mem_valid_i) begin
                    r_d.done  = 1'b1;
                    r_d.allow = map_clear;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o  = (r_q.state != ST_IDLE);
    assign mem_addr_o = r_q.addr;
    assign done_o     = r_q.done;
    assign allow_o    = r_q.done & r_q.allow;
    assign fault_o    = r_q.done & ~r_q.allow;
endmodule

// File: rtl/iopb_checker_sva.sv
`timescale 1ns/1ps
module iopb_checker_sva #(
    parameter int AW        = 32,
    parameter int LW        = 32,
    parameter int TYPE_W    = 4,
    parameter int SZW       = 3,
    parameter int PTR_OFS   = 'h66,
    parameter int TYPE_OK   = 9,
    parameter int MIN_LIMIT = 103
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [SZW-1:0]    size_i,
    input logic              desc_present_i,
    input logic [TYPE_W-1:0] desc_type_i,
    input logic [AW-1:0]     desc_base_i,
    input logic [LW-1:0]     desc_limit_i,
    input logic              mem_req_o,
    input logic [AW-1:0]     mem_addr_o,
    input logic              mem_valid_i,
    input logic              done_o,
    input logic              allow_o,
    input logic              fault_o
);
    logic good_size, good_desc;
    assign good_size = (size_i == SZW'(1)) || (size_i == SZW'(2)) || (size_i == SZW'(4));
    assign good_desc = desc_present_i && (desc_type_i == TYPE_W'(TYPE_OK)) &&
                       (desc_limit_i >= LW'(MIN_LIMIT));

    // R1: quiet state after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !done_o && !mem_req_o);

    // R2: a bad descriptor faults without memory traffic
    a_r2_bad_desc: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && !desc_present_i |=> done_o && fault_o && !mem_req_o);

    // R3: a bad size faults without memory traffic
    a_r3_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && !good_size |=> done_o && fault_o && !mem_req_o);

    // R4: first request goes to the pointer slot
    a_r4_ptr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && good_size && good_desc |=>
            mem_req_o && (mem_addr_o == $past(desc_base_i) + AW'(PTR_OFS)));

    // R8: result strobe lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: exactly one verdict with the strobe, none without it
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done_o ? (allow_o != fault_o) : (!allow_o && !fault_o));

    // R8: an allow only follows a completed read
    a_r8_allow_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(allow_o) |-> $past(mem_req_o) && $past(mem_valid_i));

    // R10: pending request holds its address
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));
endmodule

bind iopb_checker iopb_checker_sva #(
    .AW(AW), .LW(LW), .TYPE_W(TYPE_W), .SZW(SZW),
    .PTR_OFS(PTR_OFS), .TYPE_OK(TYPE_OK), .MIN_LIMIT(MIN_LIMIT)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .size_i         (size_i),
    .desc_present_i (desc_present_i),
    .desc_type_i    (desc_type_i),
    .desc_base_i    (desc_base_i),
    .desc_limit_i   (desc_limit_i),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_valid_i    (mem_valid_i),
    .done_o         (done_o),
    .allow_o        (allow_o),
    .fault_o        (fault_o)
);

// File: tb/sim_iopb_checker.sv
`timescale 1ns/1ps
module sim_iopb_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] port = '0;
    logic [2:0]  size = '0;
    logic        pres = 1'b0;
    logic [3:0]  typ = '0;
    logic [31:0] base = '0;
    logic [31:0] limit = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [15:0] mem_rdata;
    logic        done, allow, fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int lat    = 0;
    int wait_cnt = 0;
    int nreads = 0;
    logic [31:0] ra_last = '0, ra_prev = '0;
    logic [7:0] mem [1024];

    always #2.5 clk = ~clk;

    iopb_checker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .port_i(port), .size_i(size),
        .desc_present_i(pres), .desc_type_i(typ), .desc_base_i(base),
        .desc_limit_i(limit), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
        .done_o(done), .allow_o(allow), .fault_o(fault)
    );

    // memory model: little-endian 16-bit read, variable latency
    assign mem_valid = mem_req && (wait_cnt >= lat);
    assign mem_rdata = {mem[10'(mem_addr[9:0] + 10'd1)], mem[mem_addr[9:0]]};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && !mem_valid) wait_cnt <= wait_cnt + 1;
        else wait_cnt <= 0;
        if (mem_req && mem_valid) begin
            nreads  <= nreads + 1;
            ra_prev <= ra_last;
            ra_last <= mem_addr;
        end
    end

    typedef struct packed {
        logic [15:0] port;
        logic [2:0]  size;
        logic        pres;
        logic [3:0]  typ;
        logic [31:0] base;
        logic [31:0] limit;
        logic        allow;
        logic [1:0]  reads;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 3'd1, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h0007, 3'd1, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h0006, 3'd2, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h0008, 3'd2, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h0008, 3'd4, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h0007, 3'd2, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h0007, 3'd4, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h000E, 3'd4, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h000C, 3'd4, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h0010, 3'd1, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd2},
        '{16'h0011, 3'd4, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h003F, 3'd1, 1'b1, 4'h9, 32'h100, 32'h70, 1'b1, 2'd2},
        '{16'h0040, 3'd1, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd1},
        '{16'h0000, 3'd1, 1'b0, 4'h9, 32'h100, 32'h70, 1'b0, 2'd0},
        '{16'h0000, 3'd1, 1'b1, 4'hB, 32'h100, 32'h70, 1'b0, 2'd0},
        '{16'h0000, 3'd1, 1'b1, 4'h9, 32'h100, 32'h66, 1'b0, 2'd0},
        '{16'h0000, 3'd1, 1'b1, 4'h9, 32'h100, 32'h67, 1'b0, 2'd1},
        '{16'h0000, 3'd3, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd0},
        '{16'h0000, 3'd0, 1'b1, 4'h9, 32'h100, 32'h70, 1'b0, 2'd0},
        '{16'h0010, 3'd1, 1'b1, 4'h9, 32'h200, 32'h10010, 1'b0, 2'd2},
        '{16'h0010, 3'd1, 1'b1, 4'h9, 32'h200, 32'h10000, 1'b0, 2'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Runs one check; optionally sends a second start while busy (R9).
    task automatic run(input vec_t v, input bit poke_busy, input string tag);
        int  n0;
        bit  got;
        logic [31:0] ptr, exp_a2;
        n0 = nreads;
        @(negedge clk);
        port = v.port; size = v.size; pres = v.pres; typ = v.typ;
        base = v.base; limit = v.limit; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            port = 16'h0007; size = 3'd1; base = 32'h0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 1'b0;
        for (int k = 0; k < 60 && !got; k++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        check({tag, " R8 done seen"}, 32'(got), 32'd1);
        check({tag, " R7 allow"}, 32'(allow), 32'(v.allow));
        check({tag, " R8 fault"}, 32'(fault), 32'(!v.allow));
        check({tag, " R2/R3/R6 read count"}, 32'(nreads - n0), 32'(v.reads));
        ptr = {16'h0, mem[10'(v.base[9:0] + 10'h67)], mem[10'(v.base[9:0] + 10'h66)]};
        exp_a2 = v.base + ptr + 32'(v.port >> 3);
        if (v.reads == 2'd2) begin
            check({tag, " R4/R10 first addr"}, ra_prev, v.base + 32'h66);
            check({tag, " R5 second addr"}, ra_last, exp_a2);
        end else if (v.reads == 2'd1) begin
            check({tag, " R4 first addr"}, ra_last, v.base + 32'h66);
        end
        @(negedge clk);
        check({tag, " R8 single pulse"}, 32'(done), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[10'h166] = 8'h68; mem[10'h167] = 8'h00;
        mem[10'h168] = 8'h80; mem[10'h169] = 8'h00; mem[10'h16A] = 8'h01;
        mem[10'h266] = 8'hFF; mem[10'h267] = 8'hFF;
        mem[10'h201] = 8'hFF; mem[10'h202] = 8'hFF;

        repeat (3) @(negedge clk);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset req", 32'(mem_req), 32'd0);
        check("R1 reset verdict", 32'({allow, fault}), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lat = i % 3;
            run(VEC[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R9: second start during a check is dropped
        lat = 3;
        run(VEC[0], 1'b1, "busy");
        repeat (8) @(negedge clk);
        check("R9 no extra done", 32'(done), 32'd0);
        check("R9 idle after check", 32'(mem_req), 32'd0);

        // R10: long latency keeps the request and address steady
        lat = 6;
        run(VEC[7], 1'b0, "slow R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule